// File: doc/BRIEF.md
# Multichannel Serial Audio Port

This block is a master-mode serial audio port. It runs entirely in the master-clock domain. It derives a bit clock and a frame clock from the master clock, and moves 32-bit channel slots out on up to four serial output lines. At the same time it brings slots in on the same number of serial input lines. All lines share the generated bit clock and frame clock.

A frame holds either 64 bit clocks (two slots per line) or 128 bit clocks (four slots per line). A compact setting drives only line 0. Samples travel over a wide parallel bus: one 32-bit word per channel in each direction. The resolution is selectable, and the port clears the unused low bits of every word it sends or returns.

The parallel words are double-buffered. The outgoing bus is captured once per frame, at the frame boundary. The incoming bus changes only at that same boundary, where it shows the frame that has just ended. A one-cycle frame strobe tells the surrounding logic that it may present the next set of outgoing words. The frame format (slot count, compact setting and resolution) is taken into use at a frame boundary. The divider and the frame-clock polarity act directly.

Top module: `serial_audio_port`

## Requirements
- R1: The bit clock toggles every `cfg_div`+1 master-clock cycles, so its period is 2·(`cfg_div`+1) master cycles.
- R2: A frame lasts 128 bit clocks when `cfg_quad`=1 and 64 when `cfg_quad`=0. The frame clock sits at its active level for the first half of the frame and at the other level for the second half. The active level is high when `cfg_fs_pol`=1 and low when it is 0. The frame clock changes only on a falling bit-clock edge.
- R3: Each slot is 32 bits, sent most significant bit first. Bit 31 of the first slot of a frame appears one bit period after the edge into the active frame-clock level, and the slots follow back to back.
- R4: Serial outputs change only on falling bit-clock edges. Serial inputs are sampled on rising edges.
- R5: Channel c occupies bits [32c+31:32c] of `tx_data` and `rx_data`. Line l, slot s carries channel 4l+s in the 4-slot format and channel 2l+s in the 2-slot format. In the 2-slot format, channels 2·LANES and above return zero.
- R6: With `cfg_single`=1, every line except line 0 drives 0, and the channels those lines would carry return zero.
- R7: `cfg_res` holds the resolution minus one (0 means 1 bit, 31 means 32 bits). Bits below the resolution are sent as 0 and returned as 0.
- R8: `frame_strobe` is a one-cycle pulse at each frame boundary. `rx_data` changes only in that cycle, and it then holds the words received in the frame that just ended.
- R9: `tx_data` and the frame format are captured at a frame boundary and govern the whole frame that starts there.
- R10: After reset the bit clock, all serial outputs, `rx_data` and `frame_strobe` are 0, and the frame clock is at its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Bit-clock half-period in master cycles, minus one |
| cfg_quad | input | 1 | 1: four slots per line (128-bit frame); 0: two slots (64-bit frame) |
| cfg_single | input | 1 | 1: only line 0 carries audio |
| cfg_res | input | 5 | Sample resolution minus one |
| cfg_fs_pol | input | 1 | Active frame-clock level (1 = high) |
| tx_data | input | LANES·128 | Outgoing channel words, channel c at [32c+31:32c] |
| sdi | input | LANES | Serial input lines |
| bclk | output | 1 | Generated bit clock |
| fsync | output | 1 | Generated frame clock |
| sdo | output | LANES | Serial output lines |
| rx_data | output | LANES·128 | Received channel words, channel c at [32c+31:32c] |
| frame_strobe | output | 1 | One-cycle pulse at each frame boundary |

## Verification
The bench builds the port with four lines and an 8-bit divider. With four lines, the 4-slot format fills all sixteen channel words, and the 2-slot format leaves the upper eight channel words empty, so the zero return of unused channels can be observed. Three reset-separated runs use divider settings 0, 1 and 3 and both frame-clock polarities. The tightest run has a bit-clock half-period of a single master cycle, so each input sample falls in the cycle right after an output change. The frame formats change at frame boundaries in every run, which covers the hand-over between 64- and 128-bit frames and resolutions down to a single bit.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int SLOT_W    = 32;
    localparam int SLOTS_MAX = 4;
    localparam int RES_W     = $clog2(SLOT_W);
    localparam int FRAME_MAX = SLOT_W * SLOTS_MAX;
    localparam int POS_W     = $clog2(FRAME_MAX);

    typedef logic [SLOT_W-1:0] slot_t;

    // Frame format, taken into use at a frame boundary
    typedef struct packed {
        logic             quad;
        logic             single;
        logic [RES_W-1:0] res;
    } fmt_t;

    // Keeps the (res+1) most significant bits of a slot
    function automatic slot_t res_mask(input logic [RES_W-1:0] r);
        return {SLOT_W{1'b1}} << (SLOT_W - 1 - int'(r));
    endfunction

    function automatic logic [POS_W:0] frame_len(input logic quad);
        return quad ? (POS_W+1)'(FRAME_MAX) : (POS_W+1)'(FRAME_MAX / 2);
    endfunction

endpackage

// File: rtl/sap_bclk_gen.sv
module sap_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             bclk,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick      = (cnt >= div);
    assign rise_tick = tick & ~bclk;
    assign fall_tick = tick &  bclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sap_framer.sv
module sap_framer
    import sap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fall_tick,
    input  fmt_t fmt_in,
    input  logic fs_pol,
    output fmt_t fmt_run,
    output logic boundary,
    output logic fsync,
    output logic frame_strobe
);
    logic [POS_W-1:0] pos;
    logic [POS_W:0]   len;

    assign len      = frame_len(fmt_run.quad);
    // the falling edge that leaves position 0 opens the first slot
    assign boundary = fall_tick && (pos == '0);
    assign fsync    = ({1'b0, pos} < (len >> 1)) ? fs_pol : ~fs_pol;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos          <= '0;
            fmt_run      <= '0;
            frame_strobe <= 1'b0;
        end else begin
            if (fall_tick) begin
                if ({1'b0, pos} == len - (POS_W+1)'(1)) pos <= '0;
                else                                    pos <= pos + POS_W'(1);
            end
            if (boundary) fmt_run <= fmt_in;
            frame_strobe <= boundary;
        end
    end
endmodule

// File: rtl/sap_lane.sv
module sap_lane
    import sap_pkg::*;
#(
    parameter int LANE_IDX = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rise_tick,
    input  logic  fall_tick,
    input  logic  boundary,
    input  fmt_t  fmt_run,
    input  fmt_t  fmt_nxt,
    input  slot_t tx_w [SLOTS_MAX],
    input  logic  sdi_bit,
    output logic  sdo_bit,
    output slot_t rx_w [SLOTS_MAX]
);
    localparam bit IS_PRIMARY = (LANE_IDX == 0);
    localparam int HALF       = SLOTS_MAX / 2;

    logic [FRAME_MAX-1:0] tx_sh, rx_sh, load_img;
    slot_t m_nxt, m_run;
    logic  act_nxt, act_run;

    assign m_nxt   = res_mask(fmt_nxt.res);
    assign m_run   = res_mask(fmt_run.res);
    assign act_nxt = IS_PRIMARY || !fmt_nxt.single;
    assign act_run = IS_PRIMARY || !fmt_run.single;

    for (genvar s = 0; s < SLOTS_MAX; s++) begin : g_slot
        if (s < HALF) begin : g_both
            assign load_img[FRAME_MAX-1-s*SLOT_W -: SLOT_W] =
                act_nxt ? (tx_w[s] & m_nxt) : '0;
            assign rx_w[s] = !act_run ? '0 :
                fmt_run.quad ? (rx_sh[FRAME_MAX-1-s*SLOT_W -: SLOT_W] & m_run)
                             : (rx_sh[FRAME_MAX/2-1-s*SLOT_W -: SLOT_W] & m_run);
        end else begin : g_quad
            assign load_img[FRAME_MAX-1-s*SLOT_W -: SLOT_W] =
                (act_nxt && fmt_nxt.quad) ? (tx_w[s] & m_nxt) : '0;
            assign rx_w[s] = (act_run && fmt_run.quad)
                ? (rx_sh[FRAME_MAX-1-s*SLOT_W -: SLOT_W] & m_run) : '0;
        end
    end

    assign sdo_bit = tx_sh[FRAME_MAX-1];

    always_ff @(posedge clk) begin
        if (rst)            tx_sh <= '0;
        else if (boundary)  tx_sh <= load_img;
        else if (fall_tick) tx_sh <= {tx_sh[FRAME_MAX-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst)            rx_sh <= '0;
        else if (rise_tick) rx_sh <= {rx_sh[FRAME_MAX-2:0], sdi_bit};
    end

    if (!IS_PRIMARY) begin : g_idle_chk
        // R6
        idle_lane_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            fmt_run.single |-> (sdo_bit == 1'b0));
    end
endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
    import sap_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DIV_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [DIV_W-1:0]              cfg_div,
    input  logic                          cfg_quad,
    input  logic                          cfg_single,
    input  logic [4:0]                    cfg_res,
    input  logic                          cfg_fs_pol,
    input  logic [LANES*SLOTS_MAX*32-1:0] tx_data,
    input  logic [LANES-1:0]              sdi,
    output logic                          bclk,
    output logic                          fsync,
    output logic [LANES-1:0]              sdo,
    output logic [LANES*SLOTS_MAX*32-1:0] rx_data,
    output logic                          frame_strobe
);
    localparam int CH     = LANES * SLOTS_MAX;
    localparam int DATA_W = CH * SLOT_W;
    localparam int HALF   = SLOTS_MAX / 2;

    fmt_t  fmt_in, fmt_run;
    logic  rise_tick, fall_tick, boundary;
    slot_t tx_sel  [LANES][SLOTS_MAX];
    slot_t rx_lane [LANES][SLOTS_MAX];
    logic [DATA_W-1:0] rx_next;

    assign fmt_in = '{quad: cfg_quad, single: cfg_single, res: cfg_res};

    sap_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk(clk), .rst(rst), .div(cfg_div),
        .bclk(bclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    sap_framer u_framer (
        .clk(clk), .rst(rst), .fall_tick(fall_tick), .fmt_in(fmt_in),
        .fs_pol(cfg_fs_pol), .fmt_run(fmt_run), .boundary(boundary),
        .fsync(fsync), .frame_strobe(frame_strobe)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar s = 0; s < SLOTS_MAX; s++) begin : g_pick
            localparam int CQ = l * SLOTS_MAX + s;
            localparam int CD = l * HALF + s;
            if (s < HALF) begin : g_lo
                assign tx_sel[l][s] = fmt_in.quad ? tx_data[CQ*SLOT_W +: SLOT_W]
                                                  : tx_data[CD*SLOT_W +: SLOT_W];
            end else begin : g_hi
                assign tx_sel[l][s] = fmt_in.quad ? tx_data[CQ*SLOT_W +: SLOT_W] : '0;
            end
        end

        sap_lane #(.LANE_IDX(l)) u_lane (
            .clk(clk), .rst(rst), .rise_tick(rise_tick), .fall_tick(fall_tick),
            .boundary(boundary), .fmt_run(fmt_run), .fmt_nxt(fmt_in),
            .tx_w(tx_sel[l]), .sdi_bit(sdi[l]), .sdo_bit(sdo[l]),
            .rx_w(rx_lane[l])
        );
    end

    // Gather lane slots back into channel order of the frame that ended
    for (genvar c = 0; c < CH; c++) begin : g_gather
        localparam int LQ = c / SLOTS_MAX;
        localparam int SQ = c % SLOTS_MAX;
        localparam int LD = c / HALF;
        localparam int SD = c % HALF;
        if (c < LANES * HALF) begin : g_any
            assign rx_next[c*SLOT_W +: SLOT_W] = fmt_run.quad ? rx_lane[LQ][SQ]
                                                              : rx_lane[LD][SD];
        end else begin : g_quad_only
            assign rx_next[c*SLOT_W +: SLOT_W] = fmt_run.quad ? rx_lane[LQ][SQ] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           rx_data <= '0;
        else if (boundary) rx_data <= rx_next;
    end

    // R4
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo != $past(sdo)) |-> $fell(bclk));

    // R2
    fsync_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ((fsync != $past(fsync)) && $stable(cfg_fs_pol)) |-> $fell(bclk));

    // R8
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |=> !frame_strobe);

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_data != $past(rx_data)) |-> frame_strobe);
endmodule

// File: tb/serial_audio_port_bench.sv
module serial_audio_port_bench;
    localparam int LANES = 4;
    localparam int DIV_W = 8;
    localparam int CH    = LANES * 4;
    localparam int DW    = CH * 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [DIV_W-1:0] cfg_div = '0;
    logic cfg_quad = 1'b1, cfg_single = 1'b0, cfg_fs_pol = 1'b1;
    logic [4:0] cfg_res = 5'd31;
    logic [DW-1:0] tx_data = '0;
    logic [LANES-1:0] sdi = '0;
    logic bclk, fsync, frame_strobe;
    logic [LANES-1:0] sdo;
    logic [DW-1:0] rx_data;

    always #5 clk = ~clk;

    serial_audio_port #(.LANES(LANES), .DIV_W(DIV_W)) u_serial_audio_port (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_quad(cfg_quad),
        .cfg_single(cfg_single), .cfg_res(cfg_res), .cfg_fs_pol(cfg_fs_pol),
        .tx_data(tx_data), .sdi(sdi), .bclk(bclk), .fsync(fsync), .sdo(sdo),
        .rx_data(rx_data), .frame_strobe(frame_strobe)
    );

    int tests = 0, fails = 0;
    bit running = 0, synced = 0, have_full = 0, prev_bclk = 0, prev_fs = 0;
    int p = 0, half_cnt = 0, toggles = 0, frames = 0, bnd = 0;
    bit c_quad = 1, c_single = 0;
    logic [4:0] c_res = 5'd31;
    logic [DW-1:0] cur_tx = '0, cur_rxw = '0;
    logic [127:0] cap [LANES];

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bmask(input logic [4:0] r);
        return 32'hFFFF_FFFF << (31 - int'(r));
    endfunction

    function automatic int flen(input bit q);
        return q ? 128 : 64;
    endfunction

    function automatic logic [127:0] exp_stream(input int l, input bit q, input bit sg,
                                                input logic [4:0] r, input logic [DW-1:0] w);
        logic [127:0] st;
        int sl;
        st = '0;
        sl = q ? 4 : 2;
        if (sg && l > 0) return '0;
        for (int s = 0; s < sl; s++)
            st = (st << 32) | {96'b0, w[(l*sl+s)*32 +: 32] & bmask(r)};
        return st;
    endfunction

    function automatic logic [31:0] exp_rx_word(input int c, input bit q, input bit sg,
                                                input logic [4:0] r, input logic [DW-1:0] w);
        int l;
        l = c / (q ? 4 : 2);
        if (l >= LANES || (sg && l > 0)) return '0;
        return w[c*32 +: 32] & bmask(r);
    endfunction

    function automatic logic [DW-1:0] rand_words();
        logic [DW-1:0] v;
        for (int c = 0; c < CH; c++) v[c*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic next_format();
        case (bnd)
            0: begin cfg_quad = 1'b0; cfg_single = 1'b0; cfg_res = 5'd15; end
            1: begin cfg_quad = 1'b1; cfg_single = 1'b1; cfg_res = 5'd0;  end
            2: begin cfg_quad = 1'b0; cfg_single = 1'b1; cfg_res = 5'd23; end
            3: begin cfg_quad = 1'b1; cfg_single = 1'b0; cfg_res = 5'd31; end
            default: begin
                cfg_quad   = 1'($urandom);
                cfg_single = ($urandom % 4) == 0;
                cfg_res    = 5'($urandom);
            end
        endcase
    endtask

    task automatic boundary_work();
        logic [127:0] lmask;
        // R8: pulse seen in the cycle after the boundary edge
        check(frame_strobe == 1'b1, "R8 strobe at boundary", 128'(frame_strobe), 128'd1);
        if (have_full) begin
            lmask = c_quad ? '1 : {64'b0, {64{1'b1}}};
            for (int l = 0; l < LANES; l++)
                // R3 R5 R6 R7 R9: whole serial frame of each line
                check((cap[l] & lmask) == exp_stream(l, c_quad, c_single, c_res, cur_tx),
                      "R3 R5 R6 R7 R9 serial out frame", cap[l] & lmask,
                      exp_stream(l, c_quad, c_single, c_res, cur_tx));
            for (int c = 0; c < CH; c++)
                // R5 R6 R7 R8: received words of the ended frame
                check(rx_data[c*32 +: 32] == exp_rx_word(c, c_quad, c_single, c_res, cur_rxw),
                      "R5 R6 R7 R8 rx word", 128'(rx_data[c*32 +: 32]),
                      128'(exp_rx_word(c, c_quad, c_single, c_res, cur_rxw)));
            frames++;
        end
        have_full = 1;
        c_quad   = cfg_quad;
        c_single = cfg_single;
        c_res    = cfg_res;
        cur_tx   = tx_data;
        cur_rxw  = rand_words();
        tx_data  = rand_words();
        next_format();
        bnd++;
    endtask

    task automatic fall_event();
        bit edge_seen;
        int fl, sl;
        fl = flen(c_quad);
        edge_seen = (fsync == cfg_fs_pol) && (prev_fs != cfg_fs_pol);
        prev_fs = fsync;
        if (!synced) begin
            if (edge_seen) begin
                synced = 1;
                p = fl - 1;
            end
        end else begin
            p = (p + 1) % fl;
            // R2: the active frame-clock edge marks the last bit period of each frame
            check(edge_seen == (p == fl - 1), "R2 frame clock edge", 128'(edge_seen),
                  128'(p == fl - 1));
            if (p == 0) boundary_work();
            else check(frame_strobe == 1'b0, "R8 strobe idle", 128'(frame_strobe), 128'd0);
        end
        if (synced) begin
            sl = c_quad ? 4 : 2;
            for (int l = 0; l < LANES; l++)
                sdi[l] = cur_rxw[(l*sl + p/32)*32 + 31 - p%32];
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            half_cnt++;
            if (bclk != prev_bclk) begin
                // R1
                if (toggles >= 1)
                    check(half_cnt == int'(cfg_div) + 1, "R1 bit clock half period",
                          128'(half_cnt), 128'(int'(cfg_div) + 1));
                toggles++;
                half_cnt = 0;
                if (!bclk) fall_event();
                else if (synced)
                    // R4: serial outputs sampled while the bit clock rises
                    for (int l = 0; l < LANES; l++) cap[l] = {cap[l][126:0], sdo[l]};
            end
            prev_bclk = bclk;
        end
    end

    task automatic run_phase(input int dv, input bit pol, input int nfr);
        running    = 0;
        rst        = 1'b1;
        cfg_div    = DIV_W'(dv);
        cfg_fs_pol = pol;
        cfg_quad   = 1'b1;
        cfg_single = 1'b0;
        cfg_res    = 5'd31;
        tx_data    = rand_words();
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10
        check(bclk == 1'b0, "R10 reset bclk", 128'(bclk), 128'd0);
        check(sdo == '0, "R10 reset sdo", 128'(sdo), 128'd0);
        check(rx_data == '0, "R10 reset rx_data", rx_data[127:0], 128'd0);
        check(frame_strobe == 1'b0, "R10 reset strobe", 128'(frame_strobe), 128'd0);
        check(fsync == pol, "R10 reset fsync level", 128'(fsync), 128'(pol));
        synced = 0; have_full = 0; prev_bclk = 0; prev_fs = pol;
        half_cnt = 0; toggles = 0; frames = 0; bnd = 0;
        c_quad = cfg_quad; c_single = cfg_single; c_res = cfg_res;
        for (int l = 0; l < LANES; l++) cap[l] = '0;
        rst = 1'b0;
        running = 1;
        wait (frames >= nfr);
        @(negedge clk);
        running = 0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0A17));
        run_phase(1, 1'b1, 14);
        run_phase(0, 1'b0, 14);
        run_phase(3, 1'b1, 10);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule